// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block ends every processor bus cycle on an asynchronous, strobe-based bus. It watches the address strobe and two region selects: one for the peripheral expansion slot and one for the SCSI controller. It ends a cycle in one of three ways. It can drive its own active-low data acknowledge. It can step aside when an expansion card claims the cycle. It can raise an active-low bus error when a slot or SCSI access never completes.

Plain accesses are acknowledged after a short claim window, measured in clock cycles. The window gives a slot card time to assert the external acknowledge first. While the external acknowledge is low, the block's acknowledge driver is disabled so that the card can drive the shared line. For SCSI pseudo-DMA accesses, the block drives the SCSI chip select only during the claim window and then releases it. It then waits for the controller's data request. When the request arrives, it asserts data acknowledge together with a DMA acknowledge strobe of fixed width. Chip select and DMA acknowledge are never low at the same time.

A long watchdog covers only slot and SCSI accesses that have not yet been acknowledged. At the default clock of 15.6672 MHz, its default is about 265 ms.

Top module: `bus_term_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `dtack_n`, `dack_n`, `scsi_cs_n` and `berr_n` are all high (negated). All four outputs are active low.
- R2: A cycle starts at the first rising edge that samples `as_n` low. For a non-DMA access that is not claimed, `dtack_n` goes low at the CLAIM_DLY-th edge after that start edge. It stays low until `as_n` is negated.
- R3: If `ext_ack_n` is sampled low at any edge during the claim window, the block never drives `dtack_n` low for the rest of that cycle.
- R4: `dtack_oe` (1 = block drives the acknowledge line, 0 = high impedance) follows `ext_ack_n` directly: it is 0 exactly while `ext_ack_n` is low.
- R5: For a SCSI access with `dma_mode` low at the start edge, `scsi_cs_n` is low from the start edge until `as_n` is negated.
- R6: For a SCSI access with `dma_mode` high at the start edge, `scsi_cs_n` is low only during the claim window and goes high at its end. The block then holds `dtack_n` high until `drq` is sampled high. At that edge, `dtack_n` and `dack_n` both go low.
- R7: `dack_n` stays low for exactly DACK_W clock cycles and then returns high. `dtack_n` stays low until `as_n` is negated.
- R8: `scsi_cs_n` and `dack_n` are never low at the same time.
- R9: A slot or SCSI access (`sel_slot` or `sel_scsi` high at the start edge) may still be unacknowledged, or claimed by a card, at the TIMEOUT-th edge after the start edge. In that case `berr_n` goes low at that edge and the other outputs go high. They stay that way until `as_n` is negated.
- R10: An access with neither select high at the start edge never drives `berr_n` low, however long the cycle lasts.
- R11: At the first edge that samples `as_n` high, or `rst` high, all four outputs return high and the block is ready for a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low |
| sel_slot | input | 1 | Access targets the expansion slot |
| sel_scsi | input | 1 | Access targets the SCSI controller |
| dma_mode | input | 1 | SCSI access is a pseudo-DMA transfer |
| ext_ack_n | input | 1 | External card acknowledge, active low |
| drq | input | 1 | SCSI data request, active high |
| dtack_n | output | 1 | Data acknowledge value, active low |
| dtack_oe | output | 1 | Output enable for dtack_n (0 = high impedance) |
| dack_n | output | 1 | SCSI DMA acknowledge, active low |
| scsi_cs_n | output | 1 | SCSI chip select, active low |
| berr_n | output | 1 | Bus error, active low |

## Verification
The bench builds the block with CLAIM_DLY = 3, DACK_W = 4 and TIMEOUT = 40. The long watchdog therefore fires within a few dozen cycles, so bus errors can be checked on claimed slot cycles and on DMA cycles that never see a data request. The same settings show that a local cycle held for longer than the timeout raises no bus error. A claim window of three cycles lets the external acknowledge arrive in the middle of the window. A DMA acknowledge of four cycles makes an off-by-one in the pulse width visible. Strobe release in mid-window and reset in mid-cycle are also driven.

// File: rtl/bct_pkg.sv
package bct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WINDOW,
    ST_DRQWAIT,
    ST_DACK,
    ST_OWNHOLD,
    ST_EXTHOLD,
    ST_BUSERR
  } bct_state_e;

  typedef struct packed {
    logic watch;
    logic scsi;
    logic dma;
  } bct_cls_t;

endpackage

// File: rtl/bct_span_timer.sv
module bct_span_timer #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [SW-1:0] lim,
  output logic          done
);

  logic [SW-1:0] cnt_q;

  assign done = (cnt_q == lim - SW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + SW'(1);
    end
  end

  // R2 / R7: the phase counter saturates at its limit and never overruns it
  p_span_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q < lim);

endmodule

// File: rtl/bct_watchdog.sv
module bct_watchdog #(
  parameter int unsigned TIMEOUT = 4150000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic arm,
  output logic expire
);

  localparam int unsigned CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] cnt_q;

  assign expire = arm && (cnt_q == CW'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (arm && !expire) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R9: the age counter stops at the expiry value and never wraps
  p_wd_range_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(TIMEOUT));

endmodule

// File: rtl/bct_seq.sv
module bct_seq
  import bct_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       as_n,
  input  logic       sel_slot,
  input  logic       sel_scsi,
  input  logic       dma_mode,
  input  logic       ext_ack_n,
  input  logic       drq,
  input  logic       span_done,
  input  logic       wd_expire,
  output logic       span_clr,
  output logic       dack_phase,
  output logic       wd_clear,
  output logic       wd_arm,
  output logic       dtack_n,
  output logic       dack_n,
  output logic       scsi_cs_n,
  output logic       berr_n
);

  bct_state_e st_q, st_d;
  bct_cls_t   cls_q, cls_d;

  always_comb begin
    st_d  = st_q;
    cls_d = cls_q;
    if (as_n) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_d       = ST_WINDOW;
          cls_d.watch = sel_slot | sel_scsi;
          cls_d.scsi  = sel_scsi;
          cls_d.dma   = sel_scsi & dma_mode;
        end
        default: begin
          if (wd_expire) begin
            st_d = ST_BUSERR;
          end else begin
            case (st_q)
              ST_WINDOW: begin
                if (!ext_ack_n)      st_d = ST_EXTHOLD;
                else if (span_done)  st_d = cls_q.dma ? ST_DRQWAIT : ST_OWNHOLD;
              end
              ST_DRQWAIT: if (drq)       st_d = ST_DACK;
              ST_DACK:    if (span_done) st_d = ST_OWNHOLD;
              default:    st_d = st_q;
            endcase
          end
        end
      endcase
    end
  end

  assign span_clr   = (st_d != st_q);
  assign dack_phase = (st_q == ST_DACK);
  assign wd_clear   = as_n || (st_q == ST_IDLE);
  assign wd_arm     = cls_q.watch &&
                      ((st_q == ST_WINDOW) || (st_q == ST_DRQWAIT) || (st_q == ST_EXTHOLD));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cls_q     <= '0;
      dtack_n   <= 1'b1;
      dack_n    <= 1'b1;
      scsi_cs_n <= 1'b1;
      berr_n    <= 1'b1;
    end else begin
      st_q      <= st_d;
      cls_q     <= cls_d;
      dtack_n   <= !((st_d == ST_DACK) || (st_d == ST_OWNHOLD));
      dack_n    <= !(st_d == ST_DACK);
      scsi_cs_n <= !(cls_d.scsi &&
                     ((st_d == ST_WINDOW) || ((st_d == ST_OWNHOLD) && !cls_d.dma)));
      berr_n    <= !(st_d == ST_BUSERR);
    end
  end

  // R8: chip select and DMA acknowledge are mutually exclusive
  p_cs_dack_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(!scsi_cs_n && !dack_n));

  // R11: a negated strobe returns every output to its negated level
  p_release_r11: assert property (@(posedge clk) disable iff (rst)
    as_n |=> (dtack_n && dack_n && scsi_cs_n && berr_n));

  // R10: bus error only for watched (slot or SCSI) cycles
  p_berr_watch_r10: assert property (@(posedge clk) disable iff (rst)
    !berr_n |-> cls_q.watch);

  // R6: the DMA strobe only starts after a sampled data request
  p_dack_after_drq_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(dack_n) |-> $past(drq));

  // R3: a claimed cycle is never acknowledged by the block
  p_claim_no_own_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_EXTHOLD) |-> dtack_n);

endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl #(
  parameter int unsigned CLAIM_DLY = 3,
  parameter int unsigned DACK_W    = 4,
  parameter int unsigned TIMEOUT   = 4150000
) (
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  input  logic sel_slot,
  input  logic sel_scsi,
  input  logic dma_mode,
  input  logic ext_ack_n,
  input  logic drq,
  output logic dtack_n,
  output logic dtack_oe,
  output logic dack_n,
  output logic scsi_cs_n,
  output logic berr_n
);

  localparam int unsigned SPAN_MAX = (CLAIM_DLY > DACK_W) ? CLAIM_DLY : DACK_W;
  localparam int unsigned SW       = $clog2(SPAN_MAX + 1);

  logic          span_done, span_clr, dack_phase;
  logic          wd_clear, wd_arm, wd_expire;
  logic [SW-1:0] span_lim;

  assign span_lim = dack_phase ? SW'(DACK_W) : SW'(CLAIM_DLY);
  assign dtack_oe = ext_ack_n;

  bct_span_timer #(.SW(SW)) u_span (
    .clk  (clk),
    .rst  (rst),
    .clr  (span_clr),
    .lim  (span_lim),
    .done (span_done)
  );

  bct_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
    .clk    (clk),
    .rst    (rst),
    .clear  (wd_clear),
    .arm    (wd_arm),
    .expire (wd_expire)
  );

  bct_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .as_n       (as_n),
    .sel_slot   (sel_slot),
    .sel_scsi   (sel_scsi),
    .dma_mode   (dma_mode),
    .ext_ack_n  (ext_ack_n),
    .drq        (drq),
    .span_done  (span_done),
    .wd_expire  (wd_expire),
    .span_clr   (span_clr),
    .dack_phase (dack_phase),
    .wd_clear   (wd_clear),
    .wd_arm     (wd_arm),
    .dtack_n    (dtack_n),
    .dack_n     (dack_n),
    .scsi_cs_n  (scsi_cs_n),
    .berr_n     (berr_n)
  );

endmodule

// File: tb/bus_term_ctrl_tb_top.sv
module bus_term_ctrl_tb_top;

  localparam int D  = 3;
  localparam int W  = 4;
  localparam int TO = 40;

  localparam int P_IDLE = 0, P_WIN = 1, P_WAIT = 2, P_DACK = 3,
                 P_OWN = 4, P_EXT = 5, P_BERR = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_n = 1'b1, sel_slot = 1'b0, sel_scsi = 1'b0, dma_mode = 1'b0;
  logic ext_ack_n = 1'b1, drq = 1'b0;
  logic dtack_n, dtack_oe, dack_n, scsi_cs_n, berr_n;

  int n_chk = 0, n_err = 0, cyc = 0;
  int m_ph = P_IDLE, m_age = 0, m_sub = 0;
  bit m_watch = 0, m_scsi = 0, m_dma = 0;

  always #4 clk = ~clk;

  bus_term_ctrl #(.CLAIM_DLY(D), .DACK_W(W), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rst(rst), .as_n(as_n), .sel_slot(sel_slot), .sel_scsi(sel_scsi),
    .dma_mode(dma_mode), .ext_ack_n(ext_ack_n), .drq(drq),
    .dtack_n(dtack_n), .dtack_oe(dtack_oe), .dack_n(dack_n),
    .scsi_cs_n(scsi_cs_n), .berr_n(berr_n)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %b expected %b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference: phase of the cycle, age since the start edge
  always @(posedge clk) begin
    cyc++;
    if (rst || as_n) begin
      m_ph = P_IDLE;
    end else if (m_ph == P_IDLE) begin
      m_ph = P_WIN; m_age = 0;
      m_watch = sel_slot | sel_scsi; m_scsi = sel_scsi; m_dma = sel_scsi & dma_mode;
    end else begin
      m_age++;
      if (m_watch && m_age == TO && (m_ph == P_WIN || m_ph == P_WAIT || m_ph == P_EXT))
        m_ph = P_BERR;
      else if (m_ph == P_WIN) begin
        if (!ext_ack_n) m_ph = P_EXT;
        else if (m_age == D) m_ph = m_dma ? P_WAIT : P_OWN;
      end else if (m_ph == P_WAIT) begin
        if (drq) begin m_ph = P_DACK; m_sub = 0; end
      end else if (m_ph == P_DACK) begin
        m_sub++;
        if (m_sub == W) m_ph = P_OWN;
      end
    end
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog: run did not end");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // Compare against the reference away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", "dtack_n", dtack_n, !(m_ph == P_DACK || m_ph == P_OWN));
      chk("R7", "dack_n", dack_n, !(m_ph == P_DACK));
      chk("R5", "scsi_cs_n", scsi_cs_n,
          !(m_scsi && (m_ph == P_WIN || (m_ph == P_OWN && !m_dma))));
      chk("R9", "berr_n", berr_n, !(m_ph == P_BERR));
      chk("R4", "dtack_oe", dtack_oe, ext_ack_n);
      chk("R8", "cs/dack exclusive", !scsi_cs_n && !dack_n, 1'b0);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic s, input logic c, input logic d);
    @(negedge clk); #1;
    as_n = 1'b0; sel_slot = s; sel_scsi = c; dma_mode = d;
  endtask

  task automatic release_bus();
    @(negedge clk); #1;
    as_n = 1'b1; sel_slot = 1'b0; sel_scsi = 1'b0; dma_mode = 1'b0;
    ext_ack_n = 1'b1; drq = 1'b0;
    wait_n(1);
    chk("R11", "dtack_n after release", dtack_n, 1'b1);
    chk("R11", "berr_n after release", berr_n, 1'b1);
    chk("R11", "scsi_cs_n after release", scsi_cs_n, 1'b1);
  endtask

  initial begin
    wait_n(1);
    chk("R1", "dtack_n in reset", dtack_n, 1'b1);
    chk("R1", "dack_n in reset", dack_n, 1'b1);
    chk("R1", "berr_n in reset", berr_n, 1'b1);
    chk("R1", "scsi_cs_n in reset", scsi_cs_n, 1'b1);
    #1 rst = 1'b0;
    wait_n(2);

    // local access, own acknowledge after the window
    start(0, 0, 0);
    wait_n(D);
    chk("R2", "dtack_n before window end", dtack_n, 1'b1);
    wait_n(1);
    chk("R2", "dtack_n at window end", dtack_n, 1'b0);
    wait_n(5);
    release_bus();

    // slot access, not claimed
    start(1, 0, 0);
    wait_n(D + 4);
    release_bus();

    // slot access claimed inside the window, short
    start(1, 0, 0);
    wait_n(1); #1 ext_ack_n = 1'b0;
    wait_n(D + 3);
    chk("R3", "dtack_n stays high when claimed", dtack_n, 1'b1);
    chk("R4", "dtack_oe off while claimed", dtack_oe, 1'b0);
    release_bus();

    // slot access claimed and never ended: bus error
    start(1, 0, 0);
    wait_n(1); #1 ext_ack_n = 1'b0;
    wait_n(TO - 1);
    chk("R9", "berr_n just before timeout", berr_n, 1'b1);
    wait_n(1);
    chk("R9", "berr_n at timeout", berr_n, 1'b0);
    wait_n(3);
    release_bus();

    // local access claimed and held beyond the timeout
    start(0, 0, 0);
    wait_n(1); #1 ext_ack_n = 1'b0;
    wait_n(TO + 20);
    chk("R10", "no berr on local access", berr_n, 1'b1);
    release_bus();

    // SCSI register access
    start(0, 1, 0);
    wait_n(1);
    chk("R5", "scsi_cs_n low in window", scsi_cs_n, 1'b0);
    wait_n(D + 2);
    chk("R5", "scsi_cs_n low while held", scsi_cs_n, 1'b0);
    release_bus();

    // SCSI pseudo-DMA with late data request
    start(0, 1, 1);
    wait_n(D);
    chk("R6", "scsi_cs_n low in window", scsi_cs_n, 1'b0);
    wait_n(1);
    chk("R6", "scsi_cs_n released", scsi_cs_n, 1'b1);
    chk("R6", "dtack_n held waiting for drq", dtack_n, 1'b1);
    wait_n(3);
    #1 drq = 1'b1;
    wait_n(1);
    chk("R6", "dtack_n with drq", dtack_n, 1'b0);
    chk("R6", "dack_n with drq", dack_n, 1'b0);
    #1 drq = 1'b0;
    wait_n(W - 1);
    chk("R7", "dack_n last pulse cycle", dack_n, 1'b0);
    wait_n(1);
    chk("R7", "dack_n after pulse", dack_n, 1'b1);
    chk("R7", "dtack_n after pulse", dtack_n, 1'b0);
    release_bus();

    // SCSI pseudo-DMA with no data request: bus error
    start(0, 1, 1);
    wait_n(TO + 1);
    chk("R9", "berr_n on stalled DMA", berr_n, 1'b0);
    chk("R9", "scsi_cs_n on stalled DMA", scsi_cs_n, 1'b1);
    release_bus();

    // strobe released in the middle of the window
    start(1, 1, 0);
    wait_n(1);
    release_bus();

    // reset in the middle of a DMA pulse
    start(0, 1, 1);
    wait_n(D + 1); #1 drq = 1'b1;
    wait_n(2); #1 rst = 1'b1; drq = 1'b0;
    wait_n(1);
    chk("R1", "dack_n after reset", dack_n, 1'b1);
    chk("R1", "dtack_n after reset", dtack_n, 1'b1);
    #1 rst = 1'b0;
    wait_n(2);
    release_bus();

    // back-to-back local access with external acknowledge toggling late
    start(0, 0, 0);
    wait_n(D + 2); #1 ext_ack_n = 1'b0;
    wait_n(1);
    chk("R4", "dtack_oe follows ext_ack_n", dtack_oe, 1'b0);
    #1 ext_ack_n = 1'b1;
    wait_n(1);
    release_bus();

    wait_n(3);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule